// File: doc/BRIEF.md
# Debug-port interrupt request register

This block gives an external debugger a way to interrupt the CPU over a four-wire test access port. A compact test access port state machine running on TCK holds a 4-bit instruction register. Each time the debugger completes an instruction load whose opcode is the debug-interrupt code, a sticky request flag is set in the CPU clock domain and the interrupt line to the CPU goes high. The interrupt handler reads the 16-bit interrupt-factor register over a simple register bus and clears the flag by writing a 0 to bit 0. The CPU can only clear the flag. It can never set it.

While the debug-interrupt instruction is selected, the path between TDI and TDO is a 32-bit data register. It captures sixteen zero bits above the 16-bit factor register, and the debugger can poll the flag this way without help from the CPU. Every other opcode selects a one-bit bypass path. Taking the port to Test-Logic-Reset, or pulling the asynchronous TCK-domain reset low, clears the flag.

The set event crosses from TCK to the CPU clock as a toggle. The reset level of the port crosses as a synchronized level. The flag crosses back into TCK through a two-flop synchronizer so that it can be captured.

Top module: `dbg_irq_port`

## Requirements
- R1: A read pulse on `rdEn` returns the register on `rdData` in the next CPU cycle. In any cycle that follows a cycle without a read, `rdData` is zero. Bits 15 to 1 always read 0, and writes to them have no effect.
- R2: When an Update-IR completes with the instruction 4'b0101 in the instruction register, the flag (bit 0) becomes 1 a few CPU cycles later. `irq` is high for as long as the flag is 1. Loading any other opcode leaves the flag unchanged.
- R3: A CPU write with bit 0 = 0 clears the flag. A write with bit 0 = 1 leaves the flag as it was.
- R4: When a set event and a CPU clear fall in the same CPU cycle, the flag becomes 1.
- R5: The port follows the standard 16-state sequence on the rising edge of TCK, and five TCK cycles with TMS high always reach Test-Logic-Reset. Test-Logic-Reset clears the flag and sets the instruction register to BYPASS (4'b1111).
- R6: `trstN` low resets the port state machine and the instruction register at once. The flag is then cleared in the CPU domain.
- R7: Capture-IR loads 4'b0001 into the instruction shift stage. Shift-IR shifts it out on TDO with the least significant bit first.
- R8: With instruction 4'b0101, Capture-DR loads the 32-bit value {16'h0, register} into the data chain. Shift-DR shifts it out with the least significant bit first.
- R9: Any opcode other than 4'b0101 selects a one-bit bypass path. That path captures 0, so TDO repeats TDI one cycle later. Update-DR never changes the register.
- R10: TDO changes on the falling edge of TCK. `tdoEn` is 1 only while the port is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out, updated on the falling edge of TCK |
| tdoEn | output | 1 | Output enable for TDO |
| clk | input | 1 | CPU clock |
| rstN | input | 1 | CPU-domain reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid the cycle after `rdEn` |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench drives a set event while the CPU writes a clear in every cycle. A design that lets the clear win would never show `irq`, even for one cycle. It writes all ones to show that the CPU cannot set the flag and that the upper bits stay zero. It scans the 32-bit chain before and after a clear, which catches a chain that is too short or that shifts in the wrong order. It also checks that Update-DR leaves the flag alone. Reset through five TMS-high cycles and through `trstN` must both clear the flag and bring back BYPASS. An off-by-one bypass, a wrong capture value or TDO launched on the wrong edge shows up as a shifted bit pattern.

// File: rtl/dbg_irq_pkg.sv
package dbg_irq_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  // strobes from the port state machine to the datapath
  typedef struct packed {
    logic inReset;
    logic capIr;
    logic shIr;
    logic updIr;
    logic capDr;
    logic shDr;
  } tapStb_t;

endpackage

// File: rtl/dbg_irq_ctrl.sv
module dbg_irq_ctrl
  import dbg_irq_pkg::*;
(
  input  logic    tck,
  input  logic    trstN,
  input  logic    tms,
  output tapStb_t stb
);

  tapState_e st, nx;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) st <= ST_TLR;
    else        st <= nx;
  end

  always_comb begin
    case (st)
      ST_TLR:    nx = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nx = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nx = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nx = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nx = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nx = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nx = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nx = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nx = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nx = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nx = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nx = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nx = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nx = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nx = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nx = tms ? ST_SEL_DR : ST_RTI;
      default:   nx = ST_TLR;
    endcase
  end

  always_comb begin
    stb.inReset = (st == ST_TLR);
    stb.capIr   = (st == ST_CAP_IR);
    stb.shIr    = (st == ST_SH_IR);
    stb.updIr   = (st == ST_UPD_IR);
    stb.capDr   = (st == ST_CAP_DR);
    stb.shDr    = (st == ST_SH_DR);
  end

  // count of consecutive TMS-high edges, saturating at five
  logic [2:0] tmsRun;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              tmsRun <= '0;
    else if (!tms)           tmsRun <= '0;
    else if (tmsRun != 3'd5) tmsRun <= tmsRun + 3'd1;
  end

  AST_FIVE_TMS_RESET: assert property (@(posedge tck) disable iff (!trstN)
    (tmsRun == 3'd5) |-> (st == ST_TLR)); // R5
  AST_TLR_HOLDS: assert property (@(posedge tck) disable iff (!trstN)
    (st == ST_TLR && tms) |=> (st == ST_TLR)); // R5

endmodule

// File: rtl/dbg_irq_dp.sv
module dbg_irq_dp
  import dbg_irq_pkg::*;
#(
  parameter int             IR_W     = 4,
  parameter int             REG_W    = 16,
  parameter int             CHAIN_W  = 32,
  parameter logic [IR_W-1:0] OPC_INTR = 4'b0101,
  parameter int             SYNC_N   = 2
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tdi,
  input  tapStb_t          stb,
  output logic             tdo,
  output logic             tdoEn,
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);

  localparam logic [IR_W-1:0] IR_CAPT = IR_W'(1);
  localparam logic [IR_W-1:0] IR_BYP  = '1;

  // ---------------- TCK domain ----------------
  logic [IR_W-1:0]    irSh, irQ;
  logic               setTgl;
  logic [CHAIN_W-1:0] chain;
  logic               byp;
  logic [SYNC_N-1:0]  flagTs;
  logic               selIntr;

  assign selIntr = (irQ == OPC_INTR);

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irSh   <= IR_BYP;
      irQ    <= IR_BYP;
      setTgl <= 1'b0;
    end else if (stb.inReset) begin
      irSh <= IR_BYP;
      irQ  <= IR_BYP;
    end else begin
      if (stb.capIr)     irSh <= IR_CAPT;
      else if (stb.shIr) irSh <= {tdi, irSh[IR_W-1:1]};
      if (stb.updIr) begin
        irQ <= irSh;
        if (irSh == OPC_INTR) setTgl <= ~setTgl;
      end
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) flagTs <= '0;
    else        flagTs <= {flagTs[SYNC_N-2:0], irq};
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      chain <= '0;
      byp   <= 1'b0;
    end else if (stb.capDr) begin
      chain <= CHAIN_W'({{(REG_W-1){1'b0}}, flagTs[SYNC_N-1]});
      byp   <= 1'b0;
    end else if (stb.shDr) begin
      if (selIntr) chain <= {tdi, chain[CHAIN_W-1:1]};
      else         byp   <= tdi;
    end
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= stb.shIr | stb.shDr;
      if (stb.shIr)      tdo <= irSh[0];
      else if (stb.shDr) tdo <= selIntr ? chain[0] : byp;
      else               tdo <= 1'b0;
    end
  end

  // ---------------- CPU domain ----------------
  logic [SYNC_N:0]   tglSync;
  logic [SYNC_N-1:0] tlrSync;
  logic              setPulse, tlrClr, flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tglSync <= '0;
      tlrSync <= '0;
    end else begin
      tglSync <= {tglSync[SYNC_N-1:0], setTgl};
      tlrSync <= {tlrSync[SYNC_N-2:0], stb.inReset};
    end
  end

  assign setPulse = tglSync[SYNC_N] ^ tglSync[SYNC_N-1];
  assign tlrClr   = tlrSync[SYNC_N-1];

  // port reset over set, set over CPU clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    flagQ <= 1'b0;
    else if (tlrClr)              flagQ <= 1'b0;
    else if (setPulse)            flagQ <= 1'b1;
    else if (wrEn && !wrData[0])  flagQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdEn ? REG_W'(flagQ) : '0;
  end

  assign irq = flagQ;

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == '0)); // R1
  AST_UPPER_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[0] && (|wrData[REG_W-1:1]) && !setPulse) |=> !flagQ); // R1
  AST_NO_CPU_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(setPulse)); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[0] && !setPulse) |=> !flagQ); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (setPulse && !tlrClr) |=> flagQ); // R4
  AST_TLR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    tlrClr |=> !flagQ); // R5

endmodule

// File: rtl/dbg_irq_port.sv
module dbg_irq_port
  import dbg_irq_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdoEn,
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);

  tapStb_t stb;

  dbg_irq_ctrl i_ctrl (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .stb   (stb)
  );

  dbg_irq_dp #(
    .REG_W (REG_W)
  ) i_dp (
    .tck    (tck),
    .trstN  (trstN),
    .tdi    (tdi),
    .stb    (stb),
    .tdo    (tdo),
    .tdoEn  (tdoEn),
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .wrData (wrData),
    .rdData (rdData),
    .irq    (irq)
  );

endmodule

// File: tb/test_dbg_irq_port.sv
`timescale 1ns/1ps
module test_dbg_irq_port;

  localparam int CLK_PERIOD = 10;
  localparam int TCK_PERIOD = 100;

  logic tck = 0, trstN = 0, tms = 1, tdi = 0;
  logic clk = 0, rstN = 0, wrEn = 0, rdEn = 0;
  logic [15:0] wrData = '0;
  logic tdo, tdoEn, irq;
  logic [15:0] rdData;

  dbg_irq_port i_dbg_irq_port (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nCmp = 0, nBad = 0;
  bit done = 0;

  typedef struct { string req; logic [31:0] exp; } item_t;
  item_t expQ[$];

  // driver side: queue what the requirements predict
  task automatic push(input string req, input logic [31:0] exp);
    item_t it;
    it.req = req; it.exp = exp;
    expQ.push_back(it);
  endtask

  // monitor side: pop the oldest prediction and compare
  task automatic observe(input logic [31:0] act);
    item_t it;
    nCmp++;
    if (expQ.size() == 0) begin
      nBad++;
      $display("FAIL none: result %h with no prediction queued (expected none)", act);
    end else begin
      it = expQ.pop_front();
      if (act !== it.exp) begin
        nBad++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  endtask

  task automatic tckCycle(input logic tmsV, input logic tdiV,
                          output logic tdoV, output logic enV);
    tms = tmsV; tdi = tdiV;
    #(TCK_PERIOD/4);
    tdoV = tdo; enV = tdoEn;
    tck = 1;
    #(TCK_PERIOD/2);
    tck = 0;
    #(TCK_PERIOD/4);
  endtask

  task automatic idleTck(input int n, input logic tmsV);
    logic b, e;
    for (int i = 0; i < n; i++) tckCycle(tmsV, 1'b0, b, e);
  endtask

  task automatic tapReset();
    idleTck(5, 1'b1);
    idleTck(1, 1'b0);
  endtask

  task automatic loadIr(input logic [3:0] val, output logic [3:0] capt);
    logic b, e;
    tckCycle(1, 0, b, e); tckCycle(1, 0, b, e);
    tckCycle(0, 0, b, e); tckCycle(0, 0, b, e);
    for (int i = 0; i < 4; i++) begin
      tckCycle(i == 3, val[i], b, e);
      capt[i] = b;
    end
    tckCycle(1, 0, b, e); tckCycle(0, 0, b, e);
  endtask

  task automatic scanDr(input int n, input logic [31:0] din,
                        output logic [31:0] dout, output logic enAll);
    logic b, e;
    dout = '0; enAll = 1;
    tckCycle(1, 0, b, e); tckCycle(0, 0, b, e); tckCycle(0, 0, b, e);
    for (int i = 0; i < n; i++) begin
      tckCycle(i == n-1, din[i], b, e);
      dout[i] = b;
      enAll &= e;
    end
    tckCycle(1, 0, b, e); tckCycle(0, 0, b, e);
  endtask

  task automatic readReg(output logic [15:0] v);
    @(negedge clk); rdEn = 1;
    @(negedge clk); rdEn = 0; v = rdData;
  endtask

  task automatic writeReg(input logic [15:0] v);
    @(negedge clk); wrEn = 1; wrData = v;
    @(negedge clk); wrEn = 0; wrData = '0;
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  bit watchIrq = 0, seenIrq = 0;
  always @(negedge clk) if (watchIrq && irq) seenIrq = 1;

  initial begin
    #(TCK_PERIOD * 3000);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [3:0]  c;
    logic [31:0] d;
    logic        en, b, e;

    #(CLK_PERIOD * 3);
    rstN = 1; trstN = 1;
    waitClk(3);

    // reset state
    push("R6", 32'd0); observe({31'd0, irq});
    readReg(r); push("R1", 32'd0); observe({16'd0, r});
    push("R10", 32'd0); observe({31'd0, tdoEn});

    tapReset();
    loadIr(4'b1111, c);
    push("R7", 32'h1); observe({28'd0, c});
    idleTck(1, 1'b0);
    scanDr(8, 32'hA5, d, en);
    push("R9", 32'h4A); observe(d);
    waitClk(10);
    push("R2", 32'd0); observe({31'd0, irq});

    // debug-interrupt instruction sets the flag
    loadIr(4'b0101, c);
    waitClk(10);
    push("R2", 32'd1); observe({31'd0, irq});
    readReg(r); push("R2", 32'h0001); observe({16'd0, r});
    @(negedge clk); push("R1", 32'd0); observe({16'd0, rdData});

    // writing ones neither clears nor sets anything upstairs
    writeReg(16'hFFFF);
    readReg(r); push("R3", 32'h0001); observe({16'd0, r});

    // 32-bit chain, then Update-DR must not disturb the flag
    idleTck(4, 1'b0);
    scanDr(32, 32'hFFFF_FFFF, d, en);
    push("R8", 32'h0000_0001); observe(d);
    push("R10", 32'd1); observe({31'd0, en});
    tckCycle(0, 0, b, e);
    push("R10", 32'd0); observe({31'd0, e});
    waitClk(10);
    readReg(r); push("R9", 32'h0001); observe({16'd0, r});

    // CPU clear with upper bits set
    writeReg(16'hFFFE);
    readReg(r); push("R3", 32'd0); observe({16'd0, r});
    push("R3", 32'd0); observe({31'd0, irq});
    idleTck(4, 1'b0);
    scanDr(32, 32'h0, d, en);
    push("R8", 32'd0); observe(d);

    // set event against a clear held in every CPU cycle
    @(negedge clk); wrEn = 1; wrData = 16'h0000;
    seenIrq = 0; watchIrq = 1;
    loadIr(4'b0101, c);
    waitClk(10);
    watchIrq = 0;
    @(negedge clk); wrEn = 0;
    push("R4", 32'd1); observe({31'd0, seenIrq});
    waitClk(2);
    push("R4", 32'd0); observe({31'd0, irq});

    // five TMS-high cycles clear the flag and restore BYPASS
    loadIr(4'b0101, c);
    waitClk(10);
    push("R2", 32'd1); observe({31'd0, irq});
    tapReset();
    waitClk(5);
    push("R5", 32'd0); observe({31'd0, irq});
    scanDr(8, 32'hA5, d, en);
    push("R5", 32'h4A); observe(d);

    // asynchronous test reset
    loadIr(4'b0101, c);
    waitClk(10);
    push("R6", 32'd1); observe({31'd0, irq});
    tms = 1;
    #(TCK_PERIOD/4); trstN = 0;
    #(TCK_PERIOD/2); trstN = 1;
    waitClk(5);
    push("R6", 32'd0); observe({31'd0, irq});
    idleTck(1, 1'b0);
    scanDr(8, 32'h3C, d, en);
    push("R6", 32'h78); observe(d);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule